// File: doc/BRIEF.md
# Serial-Loaded 80-bit-Key Lightweight Block Cipher Engine

This block encrypts single 64-bit blocks under an 80-bit key with the PRESENT-80 lightweight block cipher. A host reaches it only through a two-wire asynchronous serial link. The host sends one fixed frame: the key, then the plaintext. When the last byte of that frame has arrived, the engine runs its rounds, one per clock. It then answers with the ciphertext on the transmit line.

Inside the block, a serial receiver and a serial transmitter sit on either side of a frame sequencer. The sequencer collects bytes into a frame buffer, starts the cipher core and then sends out the result one byte at a time. The cipher core is a single round of combinational logic between a state register and a key register. A round counter decides when the core has finished. Any byte that arrives while the engine is busy encrypting or replying is thrown away. A new frame always begins after a reply has been sent in full.

Top module: `serial_present80`

## Requirements
- R1: The receive frame is 18 bytes: first the 10 key bytes, most significant byte first, then the 8 plaintext bytes, most significant byte first.
- R2: The reply is 8 bytes holding the 64-bit ciphertext, most significant byte first. The ciphertext for an all-zero key and an all-zero plaintext is 64'h5579C1387B228445. The ciphertext for an all-ones key and an all-zero plaintext is 64'hE72C46C0F5945049.
- R3: The cipher runs 31 rounds. In each round the state is XORed with the top 64 bits of the key register. Every nibble then passes through the 4-bit S-box C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2, indexed by the nibble value. Finally bit i moves to bit (16*i) mod 63, and bit 63 stays where it is. After round 31 a final XOR with the top 64 bits of the key register gives the ciphertext.
- R4: After each round, the key register rotates left by 61 bits. Its top nibble then passes through the S-box, and the 5-bit round number (1 to 31) is XORed into bits 19 down to 15.
- R5: Serial characters have one low start bit, 8 data bits sent least significant bit first, no parity bit and one high stop bit. Each bit lasts CLKS_PER_BIT clocks, and the line is high when idle. The receiver samples each bit at its middle.
- R6: Encryption starts only after the 18th byte of a frame has arrived. The transmit line stays high for as long as a frame is being collected.
- R7: The round counter stays between 1 and 31 while the core runs. The core reports completion with a pulse that lasts exactly one cycle.
- R8: Bytes that arrive while encryption or the reply is in progress are dropped. They change neither the frame buffer nor the next result. A frame received after a reply is processed on its own.
- R9: After reset the transmit line is high and the engine is waiting for the first byte of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |

## Verification
The hardest case to reach from the ports is a byte that arrives while the engine is busy: it must leave no trace, not even a partial one. The bench produces this case by sending several stray characters right after a complete frame, so that they overlap the ciphertext transmission. It then sends a fresh frame and expects exactly the result of that frame and nothing else. The scoreboard treats any extra reply byte, or any byte transmitted while a frame is still being collected, as a failure.

// File: rtl/present80_pkg.sv
package present80_pkg;
  localparam int KEY_W  = 80;
  localparam int BLK_W  = 64;
  localparam int ROUNDS = 31;
  localparam int RC_W   = 5;

  function automatic logic [3:0] sbox4(input logic [3:0] x);
    case (x)
      4'h0: sbox4 = 4'hC; 4'h1: sbox4 = 4'h5; 4'h2: sbox4 = 4'h6; 4'h3: sbox4 = 4'hB;
      4'h4: sbox4 = 4'h9; 4'h5: sbox4 = 4'h0; 4'h6: sbox4 = 4'hA; 4'h7: sbox4 = 4'hD;
      4'h8: sbox4 = 4'h3; 4'h9: sbox4 = 4'hE; 4'hA: sbox4 = 4'hF; 4'hB: sbox4 = 4'h8;
      4'hC: sbox4 = 4'h4; 4'hD: sbox4 = 4'h7; 4'hE: sbox4 = 4'h1; default: sbox4 = 4'h2;
    endcase
  endfunction

  function automatic logic [BLK_W-1:0] sub_layer(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    for (int n = 0; n < BLK_W/4; n++) y[4*n +: 4] = sbox4(x[4*n +: 4]);
    return y;
  endfunction

  function automatic logic [BLK_W-1:0] bit_perm(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    for (int i = 0; i < BLK_W; i++) y[(i == BLK_W-1) ? i : (i*16) % (BLK_W-1)] = x[i];
    return y;
  endfunction

  function automatic logic [BLK_W-1:0] round_fn(input logic [BLK_W-1:0] s,
                                                input logic [BLK_W-1:0] rk);
    return bit_perm(sub_layer(s ^ rk));
  endfunction

  function automatic logic [KEY_W-1:0] key_step(input logic [KEY_W-1:0] k,
                                                input logic [RC_W-1:0] rc);
    logic [KEY_W-1:0] r;
    r = {k[18:0], k[KEY_W-1:19]};
    r[KEY_W-1 -: 4] = sbox4(r[KEY_W-1 -: 4]);
    r[19:15] = r[19:15] ^ rc;
    return r;
  endfunction
endpackage

// File: rtl/ser_rx.sv
module ser_rx #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  output logic       byte_vld,
  output logic [7:0] byte_dat
);
  localparam int CW = $clog2(CLKS_PER_BIT) + 1;
  localparam logic [CW-1:0] FULL = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF = CW'(CLKS_PER_BIT/2 - 1);
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_t;

  rx_st_t st_q;
  logic [1:0] sync_q;
  logic [CW-1:0] cnt_q;
  logic [2:0] bit_q;
  logic [7:0] sh_q;
  logic rx_s;

  assign rx_s = sync_q[1];
  assign byte_dat = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RX_IDLE; sync_q <= 2'b11; cnt_q <= '0; bit_q <= '0;
      sh_q <= '0; byte_vld <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd};
      byte_vld <= 1'b0;
      case (st_q)
        RX_IDLE: if (!rx_s) begin st_q <= RX_START; cnt_q <= '0; end
        RX_START:
          if (cnt_q == HALF) begin
            cnt_q <= '0; bit_q <= '0;
            st_q <= rx_s ? RX_IDLE : RX_DATA;
          end else cnt_q <= cnt_q + 1'b1;
        RX_DATA:
          if (cnt_q == FULL) begin
            cnt_q <= '0;
            sh_q <= {rx_s, sh_q[7:1]};
            if (bit_q == 3'd7) st_q <= RX_STOP;
            else bit_q <= bit_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        default:
          if (cnt_q == FULL) begin
            byte_vld <= rx_s;
            st_q <= RX_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
      endcase
    end
  end

  // R5
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);
endmodule

// File: rtl/ser_tx.sv
module ser_tx #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] data,
  output logic       txd,
  output logic       busy,
  output logic       done
);
  localparam int CW = $clog2(CLKS_PER_BIT) + 1;
  localparam logic [CW-1:0] FULL = CW'(CLKS_PER_BIT - 1);

  logic [9:0] frm_q;
  logic [CW-1:0] cnt_q;
  logic [3:0] idx_q;

  assign txd  = busy ? frm_q[0] : 1'b1;
  assign done = busy && cnt_q == FULL && idx_q == 4'd9;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q <= '1; cnt_q <= '0; idx_q <= '0; busy <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        frm_q <= {1'b1, data, 1'b0}; cnt_q <= '0; idx_q <= '0; busy <= 1'b1;
      end
    end else if (cnt_q == FULL) begin
      cnt_q <= '0;
      frm_q <= {1'b1, frm_q[9:1]};
      if (idx_q == 4'd9) busy <= 1'b0;
      else idx_q <= idx_q + 1'b1;
    end else cnt_q <= cnt_q + 1'b1;
  end

  // R5
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  // R5
  tx_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: rtl/present80_core.sv
module present80_core
  import present80_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [KEY_W-1:0] key,
  input  logic [BLK_W-1:0] pt,
  output logic             busy,
  output logic             done,
  output logic [BLK_W-1:0] ct
);
  localparam logic [RC_W-1:0] LAST_RC = RC_W'(ROUNDS);

  logic [BLK_W-1:0] st_q;
  logic [KEY_W-1:0] key_q;
  logic [RC_W-1:0]  rc_q;
  logic [BLK_W-1:0] round_key;

  assign round_key = key_q[KEY_W-1 -: BLK_W];
  assign ct = st_q ^ round_key;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0; key_q <= '0; rc_q <= '0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          st_q <= pt; key_q <= key; rc_q <= RC_W'(1); busy <= 1'b1;
        end
      end else begin
        st_q  <= round_fn(st_q, round_key);
        key_q <= key_step(key_q, rc_q);
        if (rc_q == LAST_RC) begin
          busy <= 1'b0; done <= 1'b1;
        end else rc_q <= rc_q + 1'b1;
      end
    end
  end

  // R7
  rc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rc_q >= RC_W'(1) && rc_q <= LAST_RC));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/serial_present80.sv
module serial_present80
  import present80_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  output logic txd
);
  localparam int FRAME_BYTES = (KEY_W + BLK_W) / 8;
  localparam int CT_BYTES    = BLK_W / 8;
  localparam int FCW         = $clog2(FRAME_BYTES);
  localparam int TCW         = $clog2(CT_BYTES);
  localparam logic [FCW-1:0] F_LAST = FCW'(FRAME_BYTES - 1);
  localparam logic [TCW-1:0] T_LAST = TCW'(CT_BYTES - 1);
  typedef enum logic [1:0] {ST_COLLECT, ST_CRYPT, ST_REPLY} seq_t;

  seq_t st_q;
  logic [8*FRAME_BYTES-1:0] frame_q;
  logic [FCW-1:0] bcnt_q;
  logic [TCW-1:0] tidx_q;
  logic [BLK_W-1:0] out_q;
  logic go_q, kick_q;

  logic rx_vld, tx_busy, tx_done, core_busy, core_done;
  logic [7:0] rx_byte;
  logic [BLK_W-1:0] core_ct;
  logic frame_full, byte_dropped;

  assign frame_full   = st_q == ST_COLLECT && rx_vld && bcnt_q == F_LAST;
  assign byte_dropped = st_q != ST_COLLECT && rx_vld;

  ser_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .byte_vld(rx_vld), .byte_dat(rx_byte));

  ser_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(kick_q), .data(out_q[BLK_W-1 -: 8]),
    .txd(txd), .busy(tx_busy), .done(tx_done));

  present80_core u_core (
    .clk(clk), .rst_n(rst_n), .start(go_q),
    .key(frame_q[8*FRAME_BYTES-1 -: KEY_W]), .pt(frame_q[BLK_W-1:0]),
    .busy(core_busy), .done(core_done), .ct(core_ct));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_COLLECT; frame_q <= '0; bcnt_q <= '0; tidx_q <= '0;
      out_q <= '0; go_q <= 1'b0; kick_q <= 1'b0;
    end else begin
      go_q <= 1'b0;
      kick_q <= 1'b0;
      case (st_q)
        ST_COLLECT:
          if (rx_vld) begin
            frame_q <= {frame_q[8*FRAME_BYTES-9:0], rx_byte};
            if (bcnt_q == F_LAST) begin
              bcnt_q <= '0; st_q <= ST_CRYPT; go_q <= 1'b1;
            end else bcnt_q <= bcnt_q + 1'b1;
          end
        ST_CRYPT:
          if (core_done) begin
            out_q <= core_ct; tidx_q <= '0; kick_q <= 1'b1; st_q <= ST_REPLY;
          end
        default:
          if (tx_done) begin
            out_q <= {out_q[BLK_W-9:0], 8'h00};
            if (tidx_q == T_LAST) st_q <= ST_COLLECT;
            else begin tidx_q <= tidx_q + 1'b1; kick_q <= 1'b1; end
          end
      endcase
    end
  end

  // R6
  collect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COLLECT) |-> (txd && !core_busy));
  // R8
  drop_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_dropped |=> $stable(frame_q));
  // R6
  go_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> $past(frame_full));
endmodule

// File: tb/test_serial_present80.sv
module test_serial_present80;
  localparam int CLK_PERIOD = 10;
  localparam int CPB = 8;

  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic txd;
  int checks = 0, fails = 0, got = 0, pushed = 0;
  logic [7:0] exp_q[$];
  logic done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_present80 #(.CLKS_PER_BIT(CPB)) i_serial_present80 (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd));

  function automatic logic [63:0] ref_enc(input logic [79:0] key, input logic [63:0] pt);
    logic [3:0] sb [16] = '{4'hC,4'h5,4'h6,4'hB,4'h9,4'h0,4'hA,4'hD,
                            4'h3,4'hE,4'hF,4'h8,4'h4,4'h7,4'h1,4'h2};
    logic [63:0] s, t;
    logic [79:0] k;
    s = pt; k = key;
    for (int r = 1; r <= 31; r++) begin
      s = s ^ k[79:16];
      for (int n = 0; n < 16; n++) s[4*n +: 4] = sb[s[4*n +: 4]];
      t = '0;
      for (int b = 0; b < 63; b++) t[(b*16) % 63] = s[b];
      t[63] = s[63];
      s = t;
      k = {k[18:0], k[79:19]};
      k[79:76] = sb[k[79:76]];
      k[19:15] = k[19:15] ^ 5'(r);
    end
    return s ^ k[79:16];
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    rxd = 1'b0; repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (CPB) @(negedge clk); end
    rxd = 1'b1; repeat (CPB) @(negedge clk);
  endtask

  // R1 R2: driver sends key then plaintext MSB first and queues expected reply
  task automatic send_frame(input logic [79:0] key, input logic [63:0] pt);
    logic [63:0] c;
    c = ref_enc(key, pt);
    for (int i = 7; i >= 0; i--) begin exp_q.push_back(c[8*i +: 8]); pushed++; end
    for (int i = 9; i >= 0; i--) send_byte(key[8*i +: 8]);
    for (int i = 7; i >= 0; i--) send_byte(pt[8*i +: 8]);
  endtask

  // monitor: decode txd at bit centres, compare with scoreboard
  initial begin
    logic [7:0] b;
    logic [7:0] e;
    forever begin
      @(negedge clk);
      if (rst_n && txd == 1'b0) begin
        repeat (CPB/2 - 1) @(negedge clk);
        for (int i = 0; i < 8; i++) begin repeat (CPB) @(negedge clk); b[i] = txd; end
        repeat (CPB) @(negedge clk);
        check(txd == 1'b1, "R5 stop bit", 64'(txd), 64'd1);
        got++;
        if (exp_q.size() == 0)
          check(1'b0, "R6/R8 unexpected reply byte", 64'(b), 64'hx);
        else begin
          e = exp_q.pop_front();
          check(b == e, "R2/R3/R4 ciphertext byte", 64'(b), 64'(e));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(txd == 1'b1, "R9 txd idle after reset", 64'(txd), 64'd1);
    end
    // R3 R4: model against published vectors
    check(ref_enc('0, '0) == 64'h5579C1387B228445, "R3 model vector zero",
          ref_enc('0, '0), 64'h5579C1387B228445);
    check(ref_enc('1, '0) == 64'hE72C46C0F5945049, "R4 model vector ones",
          ref_enc('1, '0), 64'hE72C46C0F5945049);
    send_frame('0, '0);
    repeat (40 + 10*CPB*9) @(negedge clk);
    send_frame('1, '0);
    repeat (40 + 10*CPB*9) @(negedge clk);
    // R8: stray bytes overlap the reply and must be dropped
    send_frame(80'h0123456789ABCDEF0123, 64'hDEADBEEFCAFEBABE);
    send_byte(8'hA5); send_byte(8'h3C); send_byte(8'hFF);
    repeat (40 + 10*CPB*9) @(negedge clk);
    send_frame('1, '1);
    repeat (40 + 10*CPB*9) @(negedge clk);
    check(got == pushed, "R8 reply byte count", 64'(got), 64'(pushed));
    check(exp_q.size() == 0, "R2 scoreboard drained", 64'(exp_q.size()), 64'd0);
    done_flag = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule